// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Level Alert

This block is a 512-word, 18-bit first-in first-out buffer. Its write side and read side run on their own clocks, which may be unrelated or may be one and the same clock. A word is stored on a write-clock edge that has the write strobe high. A word is consumed on a read-clock edge that has the read strobe high. The oldest unread word is always on the read data port and needs no read strobe to get there. So the first word written into an empty buffer appears on the output by itself, and the empty indication goes inactive at that point.

Four status outputs report the buffer state:
- active-low full;
- active-low empty;
- half-full;
- a single level alert. This output goes high when the buffer is close to either end. The distance from each end is programmable.

The two distances are loaded through the write port itself. With the configuration input held low, the first one or two write strobes after reset carry the distances on the low data bits. Those strobes store no data. An output-enable input puts the read data port into high impedance.

Top module: `dual_clk_fifo`

## Requirements
- R1: Words come out of the read data port in exactly the order they were accepted. This holds with the write and read clocks at unrelated frequencies.
- R2: The buffer holds at most 512 unread words. `full_n` is low only when 512 words are unread. A write strobe while full changes neither the stored data nor the count.
- R3: `empty_n` is low only when no unread word is present. A read strobe while `empty_n` is low has no effect. The next word written is still the next word read.
- R4: `half_full` is high when the occupancy is 256 or more. It is low when the occupancy is 255 or less.
- R5: `level_alert` is high when the occupancy is at most X, or at least 512 minus Y. It is low when the occupancy is from X+1 through 511 minus Y.
- R6: After reset, while `cfg_n` is low, the first write strobe loads X from `wr_data[8:0]`. The second write strobe loads Y from `wr_data[8:0]`. Neither strobe stores a word, so `empty_n` stays low.
- R7: If `cfg_n` rises after only one configuration strobe, Y equals X. If no configuration strobe occurs, both X and Y are 64. Any write strobe with `cfg_n` high ends the configuration phase, and that strobe stores a word.
- R8: While `rst_n` is low, the pointers are cleared and the outputs are `full_n`=1, `empty_n`=0, `half_full`=0 and `level_alert`=1.
- R9: The oldest unread word is driven on `rd_data` without a read strobe, and `empty_n` goes high when that word arrives. A read strobe with `empty_n` high consumes that word.
- R10: While `out_en_n` is high, every bit of `rd_data` is high impedance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Asynchronous active-low reset for both sides |
| wr_clk | input | 1 | Write clock |
| wr_en | input | 1 | Write strobe, sampled on the rising edge of wr_clk |
| cfg_n | input | 1 | Active-low configuration enable for the first write strobes after reset |
| wr_data | input | 18 | Write data; bits 8:0 carry the offsets during configuration |
| rd_clk | input | 1 | Read clock |
| rd_en | input | 1 | Read strobe, sampled on the rising edge of rd_clk |
| out_en_n | input | 1 | Active-low output enable for rd_data |
| rd_data | output | 18 | Oldest unread word, or high impedance |
| full_n | output | 1 | Low when 512 words are unread (write clock side) |
| empty_n | output | 1 | Low when no word is unread (read clock side) |
| half_full | output | 1 | High at 256 or more unread words (write clock side) |
| level_alert | output | 1 | High near empty (at most X words) or near full (at least 512-Y words) |

## Verification
The assertions assume that `rst_n` is held low across at least one edge of each clock before the first strobe. They also assume that `wr_en`, `cfg_n` and `rd_en` change only away from their own clock's rising edge. The bench meets both assumptions: it holds reset for several cycles of both clocks, and it drives every strobe on the falling edge of the clock it belongs to. Flags computed on one side see the other side's pointer two synchronizer stages late. For that reason the bench waits several cycles of both clocks after each burst before it compares a flag with its queue model.

// File: rtl/dual_clk_fifo_pkg.sv
package dual_clk_fifo_pkg;
  // configuration phase of the write side after reset
  typedef enum logic [1:0] {
    CFG_LOW_OFS  = 2'd0,
    CFG_HIGH_OFS = 2'd1,
    CFG_DONE     = 2'd2
  } cfg_state_e;

  localparam int DEFAULT_ADDR_W  = 9;
  localparam int DEFAULT_DATA_W  = 18;
  localparam int DEFAULT_OFFSET  = 64;
  localparam int DEFAULT_STAGES  = 2;
endpackage

// File: rtl/ptr_sync.sv
module ptr_sync #(
  parameter int W      = 10,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] pipe [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) pipe[i] <= '0;
    end else begin
      pipe[0] <= d;
      for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
    end
  end

  assign q = pipe[STAGES-1];
endmodule

// File: rtl/fifo_wr_ctrl.sv
module fifo_wr_ctrl
  import dual_clk_fifo_pkg::*;
#(
  parameter int AW      = DEFAULT_ADDR_W,
  parameter int DEF_OFS = DEFAULT_OFFSET
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          cfg_n,
  input  logic [AW-1:0] cfg_word,
  input  logic [AW:0]   rd_gray_s,
  output logic [AW:0]   wr_gray,
  output logic          mem_we,
  output logic [AW-1:0] mem_waddr,
  output logic          full_n,
  output logic          half_full,
  output logic          level_alert
);
  localparam int PW = AW + 1;
  localparam logic [PW-1:0] CAP  = {1'b1, {AW{1'b0}}};
  localparam logic [PW-1:0] HALF = {2'b01, {(AW-1){1'b0}}};

  function automatic logic [PW-1:0] bin2gray(input logic [PW-1:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [PW-1:0] gray2bin(input logic [PW-1:0] g);
    logic [PW-1:0] b;
    b[PW-1] = g[PW-1];
    for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  function automatic logic near_empty(input logic [PW-1:0] occ, input logic [AW-1:0] x);
    return occ <= {1'b0, x};
  endfunction

  function automatic logic near_full(input logic [PW-1:0] occ, input logic [AW-1:0] y);
    return occ >= (CAP - {1'b0, y});
  endfunction

  cfg_state_e    cfg_q;
  logic [AW-1:0] ofs_lo, ofs_hi;
  logic [PW-1:0] wbin, rbin_s, occ;
  logic          is_full, cfg_hit, push, push_blocked;

  assign rbin_s       = gray2bin(rd_gray_s);
  assign occ          = wbin - rbin_s;
  assign is_full      = (occ == CAP);
  assign cfg_hit      = wr_en && !cfg_n && (cfg_q != CFG_DONE);
  assign push         = wr_en && !cfg_hit && !is_full;
  assign push_blocked = wr_en && !cfg_hit && is_full;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wbin    <= '0;
      wr_gray <= '0;
      cfg_q   <= CFG_LOW_OFS;
      ofs_lo  <= AW'(DEF_OFS);
      ofs_hi  <= AW'(DEF_OFS);
    end else begin
      if (cfg_hit) begin
        if (cfg_q == CFG_LOW_OFS) begin
          ofs_lo <= cfg_word;
          ofs_hi <= cfg_word;
          cfg_q  <= CFG_HIGH_OFS;
        end else begin
          ofs_hi <= cfg_word;
          cfg_q  <= CFG_DONE;
        end
      end else if (wr_en) begin
        cfg_q <= CFG_DONE;
      end
      if (push) begin
        wbin    <= wbin + 1'b1;
        wr_gray <= bin2gray(wbin + 1'b1);
      end
    end
  end

  assign mem_we      = push;
  assign mem_waddr   = wbin[AW-1:0];
  assign full_n      = !is_full;
  assign half_full   = (occ >= HALF);
  assign level_alert = near_empty(occ, ofs_lo) || near_full(occ, ofs_hi);

  assert_no_overflow_R2: assert property (@(posedge clk) disable iff (!rst_n)
    push_blocked |=> $stable(wbin));
  assert_occ_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    occ <= CAP);
  assert_wr_gray_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wr_gray ^ $past(wr_gray)));
  assert_full_implies_half_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !full_n |-> half_full);
  assert_cfg_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_q == CFG_DONE) |=> (cfg_q == CFG_DONE));
  assert_cfg_no_store_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_hit |=> $stable(wbin));
endmodule

// File: rtl/fifo_rd_ctrl.sv
module fifo_rd_ctrl
  import dual_clk_fifo_pkg::*;
#(
  parameter int AW = DEFAULT_ADDR_W,
  parameter int DW = DEFAULT_DATA_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_en,
  input  logic [AW:0]   wr_gray_s,
  input  logic [DW-1:0] mem_rdata,
  output logic [AW-1:0] mem_raddr,
  output logic [AW:0]   cons_gray,
  output logic [DW-1:0] head_data,
  output logic          empty_n
);
  localparam int PW = AW + 1;

  function automatic logic [PW-1:0] bin2gray(input logic [PW-1:0] b);
    return b ^ (b >> 1);
  endfunction

  logic [PW-1:0] fetch_bin, fetch_gray, cons_bin;
  logic          head_valid, ram_has, pop, load;

  assign ram_has = (fetch_gray != wr_gray_s);
  assign pop     = rd_en && head_valid;
  assign load    = ram_has && (!head_valid || pop);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fetch_bin  <= '0;
      fetch_gray <= '0;
      cons_bin   <= '0;
      cons_gray  <= '0;
      head_valid <= 1'b0;
    end else begin
      if (load) begin
        fetch_bin  <= fetch_bin + 1'b1;
        fetch_gray <= bin2gray(fetch_bin + 1'b1);
      end
      if (pop) begin
        cons_bin  <= cons_bin + 1'b1;
        cons_gray <= bin2gray(cons_bin + 1'b1);
      end
      if (load)     head_valid <= 1'b1;
      else if (pop) head_valid <= 1'b0;
    end
  end

  // output word carries no reset value
  always_ff @(posedge clk) begin
    if (load) head_data <= mem_rdata;
  end

  assign mem_raddr = fetch_bin[AW-1:0];
  assign empty_n   = head_valid;

  assert_no_underflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !empty_n) |=> $stable(cons_bin));
  assert_fwft_source_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(empty_n) |-> $past(ram_has));
  assert_head_window_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_bin - cons_bin) <= PW'(1));
  assert_cons_gray_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(cons_gray ^ $past(cons_gray)));
endmodule

// File: rtl/dual_clk_fifo.sv
module dual_clk_fifo
  import dual_clk_fifo_pkg::*;
#(
  parameter int ADDR_W  = DEFAULT_ADDR_W,
  parameter int DATA_W  = DEFAULT_DATA_W,
  parameter int DEF_OFS = DEFAULT_OFFSET,
  parameter int STAGES  = DEFAULT_STAGES
) (
  input  logic              rst_n,
  input  logic              wr_clk,
  input  logic              wr_en,
  input  logic              cfg_n,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_clk,
  input  logic              rd_en,
  input  logic              out_en_n,
  output logic [DATA_W-1:0] rd_data,
  output logic              full_n,
  output logic              empty_n,
  output logic              half_full,
  output logic              level_alert
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int PW    = ADDR_W + 1;

  logic [DATA_W-1:0] store [DEPTH];
  logic [PW-1:0]     wr_gray, wr_gray_s, cons_gray, cons_gray_s;
  logic              mem_we;
  logic [ADDR_W-1:0] mem_waddr, mem_raddr;
  logic [DATA_W-1:0] mem_rdata, head_data;

  always_ff @(posedge wr_clk) begin
    if (mem_we) store[mem_waddr] <= wr_data;
  end
  assign mem_rdata = store[mem_raddr];

  fifo_wr_ctrl #(.AW(ADDR_W), .DEF_OFS(DEF_OFS)) u_wr (
    .clk        (wr_clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .cfg_n      (cfg_n),
    .cfg_word   (wr_data[ADDR_W-1:0]),
    .rd_gray_s  (cons_gray_s),
    .wr_gray    (wr_gray),
    .mem_we     (mem_we),
    .mem_waddr  (mem_waddr),
    .full_n     (full_n),
    .half_full  (half_full),
    .level_alert(level_alert)
  );

  ptr_sync #(.W(PW), .STAGES(STAGES)) u_sync_w2r (
    .clk(rd_clk), .rst_n(rst_n), .d(wr_gray), .q(wr_gray_s)
  );

  ptr_sync #(.W(PW), .STAGES(STAGES)) u_sync_r2w (
    .clk(wr_clk), .rst_n(rst_n), .d(cons_gray), .q(cons_gray_s)
  );

  fifo_rd_ctrl #(.AW(ADDR_W), .DW(DATA_W)) u_rd (
    .clk       (rd_clk),
    .rst_n     (rst_n),
    .rd_en     (rd_en),
    .wr_gray_s (wr_gray_s),
    .mem_rdata (mem_rdata),
    .mem_raddr (mem_raddr),
    .cons_gray (cons_gray),
    .head_data (head_data),
    .empty_n   (empty_n)
  );

  assign rd_data = out_en_n ? {DATA_W{1'bz}} : head_data;

  assert_reset_flags_R8: assert property (@(posedge wr_clk)
    !rst_n |-> (full_n && !empty_n && !half_full && level_alert));
endmodule

// File: tb/dual_clk_fifo_tb.sv
module dual_clk_fifo_tb;
  logic        rst_n = 1'b0;
  logic        wr_clk = 1'b0, rd_clk = 1'b0;
  logic        wr_en = 1'b0, rd_en = 1'b0, cfg_n = 1'b1, out_en_n = 1'b0;
  logic [17:0] wr_data = '0;
  tri1  [17:0] q_bus;
  logic        full_n, empty_n, half_full, level_alert;

  int n_chk = 0, n_fail = 0;
  bit finished = 0;
  logic [17:0] mq[$];

  always #10 wr_clk = ~wr_clk;
  always #13.5 rd_clk = ~rd_clk;

  dual_clk_fifo u_dut (
    .rst_n(rst_n), .wr_clk(wr_clk), .wr_en(wr_en), .cfg_n(cfg_n),
    .wr_data(wr_data), .rd_clk(rd_clk), .rd_en(rd_en), .out_en_n(out_en_n),
    .rd_data(q_bus), .full_n(full_n), .empty_n(empty_n),
    .half_full(half_full), .level_alert(level_alert)
  );

  function automatic logic [17:0] gen(input int i);
    return 18'((i * 613 + 91) ^ (i << 7)) & 18'h1FFFE;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; wr_en = 0; rd_en = 0; cfg_n = 1; out_en_n = 0;
    mq.delete();
    repeat (3) @(negedge wr_clk);
    repeat (3) @(negedge rd_clk);
    rst_n = 1'b1;
    repeat (2) @(negedge wr_clk);
  endtask

  task automatic settle();
    repeat (8) @(negedge rd_clk);
    repeat (6) @(negedge wr_clk);
  endtask

  task automatic raw_write(input logic [17:0] d);
    @(negedge wr_clk); wr_en = 1; wr_data = d;
    @(negedge wr_clk); wr_en = 0;
  endtask

  task automatic push(input logic [17:0] d);
    raw_write(d);
    if (mq.size() < 512) mq.push_back(d);
  endtask

  task automatic pop_chk(input string tag);
    int w = 0;
    @(negedge rd_clk);
    while (!empty_n && w < 60) begin @(negedge rd_clk); w++; end
    chk({tag, " head word"}, q_bus, mq[0]);
    rd_en = 1;
    @(negedge rd_clk); rd_en = 0;
    void'(mq.pop_front());
  endtask

  task automatic check_flags(input string tag, input int x, input int y);
    int occ = mq.size();
    chk({tag, " R3 empty_n"}, empty_n, occ != 0);
    chk({tag, " R2 full_n"},  full_n,  occ != 512);
    chk({tag, " R4 half_full"}, half_full, occ >= 256);
    chk({tag, " R5 level_alert"}, level_alert, (occ <= x) || (occ >= 512 - y));
  endtask

  // R8: flags during and after reset
  task automatic t_reset_state();
    rst_n = 0;
    repeat (2) @(negedge wr_clk);
    chk("R8 full_n in reset", full_n, 1);
    chk("R8 empty_n in reset", empty_n, 0);
    chk("R8 half_full in reset", half_full, 0);
    chk("R8 level_alert in reset", level_alert, 1);
    do_reset();
    check_flags("R8 after release", 64, 64);
  endtask

  // R3, R9, R10: empty reads ignored, fall-through, tri-state
  task automatic t_fall_through();
    do_reset();
    repeat (5) begin
      @(negedge rd_clk); rd_en = 1;
      @(negedge rd_clk); rd_en = 0;
    end
    settle();
    chk("R3 empty_n after empty reads", empty_n, 0);
    push(18'h0A5A5);
    settle();
    chk("R9 empty_n raised without read", empty_n, 1);
    chk("R9 word on output without read", q_bus, 18'h0A5A5);
    out_en_n = 1;
    #1 chk("R10 output released", q_bus, 18'h3FFFF);
    out_en_n = 0;
    #1 chk("R10 output driven again", q_bus, 18'h0A5A5);
    push(18'h01234);
    pop_chk("R3 first after empty reads");
    pop_chk("R9 second");
    settle();
    check_flags("R9 drained", 64, 64);
  endtask

  // R1: ordering across unrelated clocks with interleaving
  task automatic t_order();
    do_reset();
    for (int i = 0; i < 30; i++) push(gen(i + 1000));
    for (int i = 0; i < 10; i++) pop_chk("R1 order A");
    for (int i = 0; i < 10; i++) push(gen(i + 2000));
    for (int i = 0; i < 30; i++) pop_chk("R1 order B");
    settle();
    check_flags("R1 end", 64, 64);
  endtask

  // R2, R4, R5 (default offsets) and R7 default
  task automatic t_fill();
    do_reset();
    for (int i = 1; i <= 512; i++) begin
      push(gen(i));
      if (i inside {64, 65, 255, 256, 447, 448, 511, 512}) begin
        settle();
        check_flags("R7 default offsets fill", 64, 64);
      end
    end
    for (int i = 0; i < 3; i++) raw_write(18'h3FFFF);
    settle();
    check_flags("R2 after writes while full", 64, 64);
    for (int i = 0; i < 512; i++) pop_chk("R2 drain");
    settle();
    check_flags("R2 drained, no extra word", 64, 64);
  endtask

  // R6, R5: two configuration strobes
  task automatic t_program();
    do_reset();
    cfg_n = 0;
    raw_write(18'd10);
    raw_write(18'd20);
    cfg_n = 1;
    settle();
    chk("R6 config strobes store nothing", empty_n, 0);
    for (int i = 1; i <= 492; i++) begin
      push(gen(i + 3000));
      if (i inside {10, 11, 491, 492}) begin
        settle();
        check_flags("R5 programmed X=10 Y=20", 10, 20);
      end
    end
    pop_chk("R6 first stored word is data");
  endtask

  // R7: single configuration strobe, Y follows X
  task automatic t_single_prog();
    do_reset();
    cfg_n = 0;
    raw_write(18'h3F005);
    cfg_n = 1;
    for (int i = 1; i <= 507; i++) begin
      push(gen(i + 5000));
      if (i inside {5, 6, 506, 507}) begin
        settle();
        check_flags("R7 single strobe X=Y=5", 5, 5);
      end
    end
  endtask

  initial begin
    #(20ns * 190000);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    t_reset_state();
    t_fall_through();
    t_order();
    t_fill();
    t_program();
    t_single_prog();
    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule